// File: doc/BRIEF.md
# Auto-Stepping Memory Pointer Unit

This block holds the data-side address of a small processor core. It has a pointer register that supplies the byte address for single loads, single stores and block moves, and a segment register that picks the memory bank for that address. A persistent mode register sets the direction of block moves, load or store. It also sets what the pointer does after each move: it stays where it is, counts up or counts down.

The decoder drives one-cycle strobes. These write the pointer from the ALU value or from the stack value, add the ALU value to the pointer, write the segment, change either mode field, or report that a block-move access has taken place. The pointer add also drives the core's single branch flag, which takes the carry out of the addition. The memory array and the instruction decode sit outside this block.

The reset input pulls every register low as soon as it goes low. Its release passes through a synchronizer, so the registers leave reset on a clock edge.

Top module: `ptrstep_unit`

## Requirements
- R1: During reset and after it, the pointer, segment and flag read zero, the direction output reads load (0), and the step mode is hold, so a move leaves the pointer unchanged.
- R2: A set-pointer strobe loads the ALU value into the pointer on the next clock edge.
- R3: A stack-load strobe loads the stack value into the pointer on the next clock edge.
- R4: A pointer-add strobe replaces the pointer with the sum of the pointer and the ALU value, modulo 2^PTR_W, and sets the flag to the carry out of that sum.
- R5: The flag changes only on a pointer add that is carried out. At all other times it keeps its value, including when the add loses to a higher-priority pointer write.
- R6: A move strobe steps the pointer by the step mode held before that edge. Code 01 counts up, code 10 counts down, and both wrap modulo 2^PTR_W. Code 00 (hold) and the spare code 11 leave the pointer unchanged.
- R7: When several pointer strobes arrive together, only one takes effect, in the priority set-pointer, then stack-load, then add, then move.
- R8: A segment strobe loads the ALU value into the segment. No pointer strobe changes the segment, and a segment write in the same cycle as a pointer write does not disturb it.
- R9: The direction field (0 load, 1 store, shown on the direction output) and the step field are written by separate strobes. Each write leaves the other field unchanged, and both may be written in the same cycle.
- R10: A move in the same cycle as a step-mode write uses the step mode held before that write. The new mode applies from the next move onward.
- R11: Reset low clears the registers at once, with no clock. After reset rises, strobes on the first SYNC_STAGES clock edges (two by default) are ignored, and the next edge accepts them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronized release |
| ptr_set | input | 1 | Load pointer from ALU value |
| ptr_pop | input | 1 | Load pointer from stack value |
| ptr_add | input | 1 | Add ALU value to pointer and update flag |
| mv_strobe | input | 1 | A block-move access took place this cycle; apply the post-step |
| seg_set | input | 1 | Load segment from ALU value |
| mode_dir_wr | input | 1 | Write the direction field |
| mode_dir_val | input | 1 | New direction: 0 load, 1 store |
| mode_step_wr | input | 1 | Write the step field |
| mode_step_val | input | 2 | New step: 00 hold, 01 up, 10 down, 11 spare (hold) |
| alu_val | input | PTR_W | ALU output value |
| stack_val | input | PTR_W | Stack output value |
| ptr_q | output | PTR_W | Current pointer (data address) |
| seg_q | output | SEG_W | Current segment |
| mv_store | output | 1 | Block-move direction: 1 store, 0 load |
| flag_q | output | 1 | Branch flag (carry of the last pointer add) |

## Verification
The hardest states to reach from the ports are the cycles where a mode write lands on the same edge as a move, and where several pointer strobes compete. In those cycles the result depends on which register value is sampled and on the priority order. The stimulus table drives these collisions on single rows: a step change with a move, set-pointer with add, stack-load with add, and add with move. Each row follows rows that put the pointer near a wrap boundary and leave the flag in a known state. A directed phase pulls reset low between clock edges and then holds a set-pointer strobe across the release, so the bench can see which edge first accepts it.

// File: rtl/ptrstep_pkg.sv
package ptrstep_pkg;

  // Block-move direction field
  typedef enum logic {
    DIR_LOAD  = 1'b0,
    DIR_STORE = 1'b1
  } dir_e;

  // Post-move step field; code 11 is spare and acts as hold
  typedef enum logic [1:0] {
    STEP_HOLD = 2'b00,
    STEP_UP   = 2'b01,
    STEP_DOWN = 2'b10,
    STEP_SPR  = 2'b11
  } step_e;

  // Which pointer source wins in a cycle
  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_SET  = 3'd1,
    SRC_POP  = 3'd2,
    SRC_ADD  = 3'd3,
    SRC_MOVE = 3'd4
  } src_e;

endpackage

// File: rtl/ptrstep_rst_sync.sv
module ptrstep_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb chain_d = 1'b1;
    end else begin : g_multi
      always_comb chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_n_out = chain_q[STAGES-1];

  // R11
  rst_release_chk: assert property (@(posedge clk) disable iff (!rst_n_in)
    $rose(rst_n_out) |-> $past(rst_n_in));

endmodule

// File: rtl/ptrstep_mode_reg.sv
module ptrstep_mode_reg
  import ptrstep_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dir_wr,
  input  logic       dir_val,
  input  logic       step_wr,
  input  logic [1:0] step_val,
  output dir_e       dir_q,
  output step_e      step_q
);

  dir_e  dir_d;
  step_e step_d;
  logic  dir_en;
  logic  step_en;

  // Each field has its own enable so a write to one never disturbs the other
  always_comb begin
    dir_en  = dir_wr;
    step_en = step_wr;
    dir_d   = dir_val ? DIR_STORE : DIR_LOAD;
    step_d  = step_e'(step_val);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dir_q <= DIR_LOAD;
    else if (dir_en) dir_q <= dir_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       step_q <= STEP_HOLD;
    else if (step_en) step_q <= step_d;
  end

  // R9
  dir_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dir_wr |=> $stable(dir_q));

  // R9
  step_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !step_wr |=> $stable(step_q));

  // R9
  step_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_wr |=> step_q == $past(step_val));

endmodule

// File: rtl/ptrstep_seg_reg.sv
module ptrstep_seg_reg #(
  parameter int SEG_W = 8,
  parameter int SRC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [SRC_W-1:0] src,
  output logic [SEG_W-1:0] seg_q
);

  logic [SEG_W-1:0] seg_d;

  generate
    if (SRC_W >= SEG_W) begin : g_trunc
      always_comb seg_d = src[SEG_W-1:0];
    end else begin : g_pad
      always_comb seg_d = {{(SEG_W-SRC_W){1'b0}}, src};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    seg_q <= '0;
    else if (load) seg_q <= seg_d;
  end

  // R8
  seg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(seg_q));

endmodule

// File: rtl/ptrstep_ptr_core.sv
module ptrstep_ptr_core
  import ptrstep_pkg::*;
#(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_i,
  input  logic             pop_i,
  input  logic             add_i,
  input  logic             move_i,
  input  step_e            step_i,
  input  logic [PTR_W-1:0] alu_i,
  input  logic [PTR_W-1:0] stack_i,
  output logic [PTR_W-1:0] ptr_q,
  output logic             flag_q
);

  localparam logic [PTR_W-1:0] ONE = PTR_W'(1);

  src_e             src_sel;
  logic [PTR_W:0]   add_full;
  logic [PTR_W-1:0] step_val;
  logic [PTR_W-1:0] ptr_d;
  logic             ptr_en;
  logic             flag_d;
  logic             flag_en;

  // Fixed priority among pointer writers
  always_comb begin
    if (set_i)       src_sel = SRC_SET;
    else if (pop_i)  src_sel = SRC_POP;
    else if (add_i)  src_sel = SRC_ADD;
    else if (move_i) src_sel = SRC_MOVE;
    else             src_sel = SRC_NONE;
  end

  always_comb begin
    add_full = {1'b0, ptr_q} + {1'b0, alu_i};
    unique case (step_i)
      STEP_UP:   step_val = ptr_q + ONE;
      STEP_DOWN: step_val = ptr_q - ONE;
      default:   step_val = ptr_q;
    endcase
  end

  always_comb begin
    ptr_d   = ptr_q;
    ptr_en  = 1'b0;
    flag_d  = flag_q;
    flag_en = 1'b0;
    unique case (src_sel)
      SRC_SET: begin
        ptr_d  = alu_i;
        ptr_en = 1'b1;
      end
      SRC_POP: begin
        ptr_d  = stack_i;
        ptr_en = 1'b1;
      end
      SRC_ADD: begin
        ptr_d   = add_full[PTR_W-1:0];
        ptr_en  = 1'b1;
        flag_d  = add_full[PTR_W];
        flag_en = 1'b1;
      end
      SRC_MOVE: begin
        ptr_d  = step_val;
        ptr_en = (step_i == STEP_UP) || (step_i == STEP_DOWN);
      end
      default: begin
        ptr_d  = ptr_q;
        ptr_en = 1'b0;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  // R2
  ptr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> ptr_q == $past(alu_i));

  // R3
  ptr_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && !set_i) |=> ptr_q == $past(stack_i));

  // R4
  ptr_add_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (add_i && !set_i && !pop_i) |=>
      {flag_q, ptr_q} == ({1'b0, $past(ptr_q)} + {1'b0, $past(alu_i)}));

  // R5
  flag_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(add_i && !set_i && !pop_i) |=> $stable(flag_q));

  // R6
  step_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (move_i && !set_i && !pop_i && !add_i && step_i == STEP_UP) |=>
      ptr_q == $past(ptr_q) + ONE);

  // R6
  step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (move_i && !set_i && !pop_i && !add_i && step_i == STEP_DOWN) |=>
      ptr_q == $past(ptr_q) - ONE);

  // R6
  step_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!set_i && !pop_i && !add_i &&
     !(move_i && (step_i == STEP_UP || step_i == STEP_DOWN))) |=> $stable(ptr_q));

endmodule

// File: rtl/ptrstep_unit.sv
module ptrstep_unit
  import ptrstep_pkg::*;
#(
  parameter int PTR_W       = 8,
  parameter int SEG_W       = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ptr_set,
  input  logic             ptr_pop,
  input  logic             ptr_add,
  input  logic             mv_strobe,
  input  logic             seg_set,
  input  logic             mode_dir_wr,
  input  logic             mode_dir_val,
  input  logic             mode_step_wr,
  input  logic [1:0]       mode_step_val,
  input  logic [PTR_W-1:0] alu_val,
  input  logic [PTR_W-1:0] stack_val,
  output logic [PTR_W-1:0] ptr_q,
  output logic [SEG_W-1:0] seg_q,
  output logic             mv_store,
  output logic             flag_q
);

  logic  rst_n_sync;
  dir_e  dir_cur;
  step_e step_cur;

  ptrstep_rst_sync #(
    .STAGES (SYNC_STAGES)
  ) i_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_sync)
  );

  ptrstep_mode_reg i_mode (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .dir_wr   (mode_dir_wr),
    .dir_val  (mode_dir_val),
    .step_wr  (mode_step_wr),
    .step_val (mode_step_val),
    .dir_q    (dir_cur),
    .step_q   (step_cur)
  );

  ptrstep_ptr_core #(
    .PTR_W (PTR_W)
  ) i_ptr (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .set_i   (ptr_set),
    .pop_i   (ptr_pop),
    .add_i   (ptr_add),
    .move_i  (mv_strobe),
    .step_i  (step_cur),
    .alu_i   (alu_val),
    .stack_i (stack_val),
    .ptr_q   (ptr_q),
    .flag_q  (flag_q)
  );

  ptrstep_seg_reg #(
    .SEG_W (SEG_W),
    .SRC_W (PTR_W)
  ) i_seg (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .load  (seg_set),
    .src   (alu_val),
    .seg_q (seg_q)
  );

  assign mv_store = (dir_cur == DIR_STORE);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    !rst_n_sync |-> (ptr_q == '0 && seg_q == '0 && !flag_q && !mv_store));

endmodule

// File: tb/test_ptrstep_unit.sv
module test_ptrstep_unit;

  localparam int CLK_PERIOD = 10;
  localparam int NVEC       = 25;

  typedef struct packed {
    logic [7:0] cmd;   // set,pop,add,mv,segw,dirw,dirv,stw
    logic [1:0] stv;
    logic [7:0] alu;
    logic [7:0] stk;
    logic [7:0] eptr;
    logic [7:0] eseg;
    logic       eflag;
    logic       estore;
    logic [3:0] req;
  } vec_t;

  function automatic vec_t mk(input logic [7:0] cmd, input logic [1:0] stv,
                              input logic [7:0] alu, input logic [7:0] stk,
                              input logic [7:0] eptr, input logic [7:0] eseg,
                              input logic ef, input logic es, input logic [3:0] req);
    vec_t v;
    v.cmd = cmd; v.stv = stv; v.alu = alu; v.stk = stk;
    v.eptr = eptr; v.eseg = eseg; v.eflag = ef; v.estore = es; v.req = req;
    return v;
  endfunction

  // cmd bits: set pop add mv segw dirw dirv stw
  localparam vec_t VECS [NVEC] = '{
    mk(8'b1000_0000, 2'b00, 8'hF0, 8'h00, 8'hF0, 8'h00, 1'b0, 1'b0, 4'd2),  // R2 set
    mk(8'b0000_1000, 2'b00, 8'h5A, 8'h00, 8'hF0, 8'h5A, 1'b0, 1'b0, 4'd8),  // R8 segment
    mk(8'b0000_0001, 2'b01, 8'h00, 8'h00, 8'hF0, 8'h5A, 1'b0, 1'b0, 4'd9),  // R9 step up
    mk(8'b0001_0000, 2'b00, 8'h00, 8'h00, 8'hF1, 8'h5A, 1'b0, 1'b0, 4'd6),  // R6 up
    mk(8'b0000_0110, 2'b00, 8'h00, 8'h00, 8'hF1, 8'h5A, 1'b0, 1'b1, 4'd9),  // R9 store
    mk(8'b0010_0000, 2'b00, 8'h20, 8'h00, 8'h11, 8'h5A, 1'b1, 1'b1, 4'd4),  // R4 carry
    mk(8'b0010_0000, 2'b00, 8'h01, 8'h00, 8'h12, 8'h5A, 1'b0, 1'b1, 4'd4),  // R4 no carry
    mk(8'b0100_0000, 2'b00, 8'h00, 8'hFF, 8'hFF, 8'h5A, 1'b0, 1'b1, 4'd3),  // R3 pop
    mk(8'b0001_0000, 2'b00, 8'h00, 8'h00, 8'h00, 8'h5A, 1'b0, 1'b1, 4'd6),  // R6 wrap up
    mk(8'b0001_0001, 2'b10, 8'h00, 8'h00, 8'h01, 8'h5A, 1'b0, 1'b1, 4'd10), // R10 old mode
    mk(8'b0001_0000, 2'b00, 8'h00, 8'h00, 8'h00, 8'h5A, 1'b0, 1'b1, 4'd6),  // R6 down
    mk(8'b0001_0000, 2'b00, 8'h00, 8'h00, 8'hFF, 8'h5A, 1'b0, 1'b1, 4'd6),  // R6 wrap down
    mk(8'b0001_0001, 2'b11, 8'h00, 8'h00, 8'hFE, 8'h5A, 1'b0, 1'b1, 4'd10), // R10 down still used
    mk(8'b0001_0001, 2'b00, 8'h00, 8'h00, 8'hFE, 8'h5A, 1'b0, 1'b1, 4'd6),  // R6 spare holds
    mk(8'b0001_0000, 2'b00, 8'h00, 8'h00, 8'hFE, 8'h5A, 1'b0, 1'b1, 4'd6),  // R6 hold
    mk(8'b1010_0000, 2'b00, 8'h10, 8'h00, 8'h10, 8'h5A, 1'b0, 1'b1, 4'd7),  // R7 set beats add, R5
    mk(8'b0010_0000, 2'b00, 8'hF0, 8'h00, 8'h00, 8'h5A, 1'b1, 1'b1, 4'd4),  // R4 exact wrap
    mk(8'b0110_0000, 2'b00, 8'h01, 8'h33, 8'h33, 8'h5A, 1'b1, 1'b1, 4'd5),  // R5 pop beats add
    mk(8'b0000_0001, 2'b01, 8'h00, 8'h00, 8'h33, 8'h5A, 1'b1, 1'b1, 4'd9),  // R9 step up
    mk(8'b0011_0000, 2'b00, 8'h02, 8'h00, 8'h35, 8'h5A, 1'b0, 1'b1, 4'd7),  // R7 add beats move
    mk(8'b0001_1000, 2'b00, 8'h77, 8'h00, 8'h36, 8'h77, 1'b0, 1'b1, 4'd8),  // R8 seg with move
    mk(8'b1000_1000, 2'b00, 8'h80, 8'h00, 8'h80, 8'h80, 1'b0, 1'b1, 4'd8),  // R8 seg with set
    mk(8'b0000_0101, 2'b10, 8'h00, 8'h00, 8'h80, 8'h80, 1'b0, 1'b0, 4'd9),  // R9 both fields
    mk(8'b0001_0000, 2'b00, 8'h00, 8'h00, 8'h7F, 8'h80, 1'b0, 1'b0, 4'd6),  // R6 down
    mk(8'b0000_0000, 2'b00, 8'h00, 8'h00, 8'h7F, 8'h80, 1'b0, 1'b0, 4'd5)   // R5 idle
  };

  logic       clk;
  logic       rst_n;
  logic       ptr_set, ptr_pop, ptr_add, mv_strobe, seg_set;
  logic       mode_dir_wr, mode_dir_val, mode_step_wr;
  logic [1:0] mode_step_val;
  logic [7:0] alu_val, stack_val;
  logic [7:0] ptr_q, seg_q;
  logic       mv_store, flag_q;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  ptrstep_unit i_ptrstep_unit (
    .clk           (clk),
    .rst_n         (rst_n),
    .ptr_set       (ptr_set),
    .ptr_pop       (ptr_pop),
    .ptr_add       (ptr_add),
    .mv_strobe     (mv_strobe),
    .seg_set       (seg_set),
    .mode_dir_wr   (mode_dir_wr),
    .mode_dir_val  (mode_dir_val),
    .mode_step_wr  (mode_step_wr),
    .mode_step_val (mode_step_val),
    .alu_val       (alu_val),
    .stack_val     (stack_val),
    .ptr_q         (ptr_q),
    .seg_q         (seg_q),
    .mv_store      (mv_store),
    .flag_q        (flag_q)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {ptr,seg,flag,store} actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle_inputs();
    ptr_set = 0; ptr_pop = 0; ptr_add = 0; mv_strobe = 0; seg_set = 0;
    mode_dir_wr = 0; mode_dir_val = 0; mode_step_wr = 0; mode_step_val = 2'b00;
    alu_val = 8'h00; stack_val = 8'h00;
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_inputs();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1: state held at zero during reset
    check("R1", {ptr_q, seg_q, flag_q, mv_store}, 18'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      {ptr_set, ptr_pop, ptr_add, mv_strobe, seg_set, mode_dir_wr, mode_dir_val,
       mode_step_wr} = VECS[i].cmd;
      mode_step_val = VECS[i].stv;
      alu_val       = VECS[i].alu;
      stack_val     = VECS[i].stk;
      @(negedge clk);
      check($sformatf("R%0d row %0d", VECS[i].req, i),
            {ptr_q, seg_q, flag_q, mv_store},
            {VECS[i].eptr, VECS[i].eseg, VECS[i].eflag, VECS[i].estore});
    end

    // R11: asynchronous clear between clock edges
    idle_inputs();
    #2 rst_n = 1'b0;
    #1 check("R11 async clear", {ptr_q, seg_q, flag_q, mv_store}, 18'h0);
    @(negedge clk);
    rst_n   = 1'b1;
    ptr_set = 1'b1;
    alu_val = 8'hAA;
    @(negedge clk);
    check("R11 edge 1 ignored", {ptr_q, seg_q, flag_q, mv_store}, 18'h0);
    @(negedge clk);
    check("R11 edge 2 ignored", {ptr_q, seg_q, flag_q, mv_store}, 18'h0);
    @(negedge clk);
    check("R11 edge 3 accepted", {ptr_q, seg_q, flag_q, mv_store}, {8'hAA, 8'h00, 1'b0, 1'b0});
    // R1: step mode back at hold after reset
    ptr_set   = 1'b0;
    mv_strobe = 1'b1;
    @(negedge clk);
    check("R1 hold after reset", {ptr_q, seg_q, flag_q, mv_store}, {8'hAA, 8'h00, 1'b0, 1'b0});
    idle_inputs();
    @(negedge clk);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule